// File: doc/BRIEF.md
# Neighbour-Latching Byte Register File

A storage block for a small compute element in a cluster of four such elements. It holds 32 eight-bit registers and serves two read ports and one write port, all addressed by byte. Any port can also work on a 16-bit operand. A 16-bit operand is the pair made of an even register, which supplies the low byte, and the odd register that follows it, which supplies the high byte.

The six highest registers also act as receive ports for the other three members of the cluster. Each member drives a 16-bit bus with a valid flag into this block. The static element index tells the block which member it is, and so which bus feeds which register. When an enabled read names a bus-backed register and that register's source bus is valid, the port returns the live bus byte in the same cycle. The register also stores that byte at the next clock edge. If the source bus is idle, the read returns the stored byte and nothing changes.

Top module: `nbr_byte_rf`

## Requirements
- R1: After reset is released, every register reads as 0x00.
- R2: A byte read returns the addressed register in bits 7:0 and zero in bits 15:8, in the same cycle, whether or not the port is enabled.
- R3: A 16-bit read at an even address A returns register A+1 in bits 15:8 and register A in bits 7:0.
- R4: An enabled 16-bit read at an odd address sets that port's error output in the same cycle and returns the pair at the address with bit 0 cleared. The error output is low for any other read.
- R5: A byte write stores write data bits 7:0 at the address. A 16-bit write stores bits 7:0 at the address with bit 0 cleared and bits 15:8 at the address with bit 0 set. Both are visible from the next cycle.
- R6: With element index i, registers 26 and 27 take bits 7:0 and 15:8 of the bus from member (i+1) mod 4. Registers 28 and 29 take them from member (i+2) mod 4, and registers 30 and 31 from member (i+3) mod 4. Member i's own bus is never used.
- R7: An enabled read covering a bus-backed register whose source bus is valid returns the live byte in the same cycle. The register stores that byte at the clock edge. A 16-bit read latches both bytes of the pair.
- R8: A bus-backed register is left unchanged, and its stored value is returned, when its source bus is not valid, or when the read port is not enabled even though the bus is valid.
- R9: If the write port and a bus latch target the same register in the same cycle, the register takes the bus byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| elem_idx_i | input | 2 | Static index of this member within the cluster |
| bus_data_i | input | 4x16 | Incoming bus of each cluster member, indexed by member |
| bus_vld_i | input | 4 | Valid flag per member bus |
| rd_a_en_i | input | 1 | Port A read enable (allows latching) |
| rd_a_wide_i | input | 1 | Port A 16-bit mode |
| rd_a_addr_i | input | 5 | Port A byte address |
| rd_a_data_o | output | 16 | Port A read data |
| rd_a_err_o | output | 1 | Port A odd 16-bit address flag |
| rd_b_en_i | input | 1 | Port B read enable (allows latching) |
| rd_b_wide_i | input | 1 | Port B 16-bit mode |
| rd_b_addr_i | input | 5 | Port B byte address |
| rd_b_data_o | output | 16 | Port B read data |
| rd_b_err_o | output | 1 | Port B odd 16-bit address flag |
| wr_en_i | input | 1 | Write enable |
| wr_wide_i | input | 1 | 16-bit write mode |
| wr_addr_i | input | 5 | Write byte address |
| wr_data_i | input | 16 | Write data |

## Verification
The neighbour mapping is tried with every element index in turn. Each member's bus carries a distinct value, and the own member's bus carries a decoy, so a wrong rotation or a wrong byte lane gives a visible mismatch. Reads with the bus idle, reads with the bus valid but the port disabled, and reads with both set are run back to back, then followed by idle-bus reads. This separates live forwarding from storage and shows whether a disabled read latches. A write and a latch aimed at the same register show which one wins. Random cycles then mix odd and even 16-bit accesses on both ports against a bench-side model of the register contents.

// File: rtl/nbr_rf_pkg.sv
package nbr_rf_pkg;
  localparam int unsigned RF_NREG   = 32;
  localparam int unsigned RF_BYTE_W = 8;
  localparam int unsigned RF_NMEMB  = 4;

  // distance from this member to the source of a bus-backed slot
  function automatic int unsigned nbr_offset(input int unsigned slot);
    return slot / 2 + 1;
  endfunction
endpackage

// File: rtl/nbr_rf_map.sv
module nbr_rf_map #(
  parameter int unsigned NMEMB  = nbr_rf_pkg::RF_NMEMB,
  parameter int unsigned BYTE_W = nbr_rf_pkg::RF_BYTE_W,
  localparam int unsigned IDX_W = $clog2(NMEMB),
  localparam int unsigned NSLOT = 2 * (NMEMB - 1)
) (
  input  logic [IDX_W-1:0]                  elem_idx_i,
  input  logic [NMEMB-1:0][2*BYTE_W-1:0]    bus_data_i,
  input  logic [NMEMB-1:0]                  bus_vld_i,
  output logic [NSLOT-1:0][BYTE_W-1:0]      live_byte_o,
  output logic [NSLOT-1:0]                  live_vld_o
);
  for (genvar j = 0; j < NSLOT; j++) begin : g_slot
    localparam int unsigned OFF = nbr_rf_pkg::nbr_offset(j);
    logic [IDX_W-1:0] src;
    // index wraps modulo the power-of-two cluster size
    assign src = elem_idx_i + IDX_W'(OFF);
    assign live_vld_o[j] = bus_vld_i[src];
    if (j % 2 == 0) begin : g_lo
      assign live_byte_o[j] = bus_data_i[src][BYTE_W-1:0];
    end else begin : g_hi
      assign live_byte_o[j] = bus_data_i[src][2*BYTE_W-1:BYTE_W];
    end
  end
endmodule

// File: rtl/nbr_rf_rd_port.sv
module nbr_rf_rd_port #(
  parameter int unsigned NREG   = nbr_rf_pkg::RF_NREG,
  parameter int unsigned BYTE_W = nbr_rf_pkg::RF_BYTE_W,
  parameter int unsigned NSLOT  = 6,
  localparam int unsigned AW    = $clog2(NREG),
  localparam int unsigned BASE  = NREG - NSLOT
) (
  input  logic                         en_i,
  input  logic                         wide_i,
  input  logic [AW-1:0]                addr_i,
  input  logic [NREG-1:0][BYTE_W-1:0]  regs_i,
  input  logic [NSLOT-1:0][BYTE_W-1:0] live_byte_i,
  input  logic [NSLOT-1:0]             live_vld_i,
  output logic [2*BYTE_W-1:0]          data_o,
  output logic                         err_o,
  output logic [NSLOT-1:0]             latch_o
);
  logic [AW-1:0]     lo_addr, hi_addr;
  logic [BYTE_W-1:0] lo_b, hi_b;

  assign lo_addr = wide_i ? {addr_i[AW-1:1], 1'b0} : addr_i;
  assign hi_addr = {lo_addr[AW-1:1], 1'b1};

  always_comb begin
    lo_b    = regs_i[lo_addr];
    hi_b    = regs_i[hi_addr];
    latch_o = '0;
    for (int j = 0; j < NSLOT; j++) begin
      if (en_i && live_vld_i[j]) begin
        if (lo_addr == AW'(BASE + j)) begin
          lo_b       = live_byte_i[j];
          latch_o[j] = 1'b1;
        end
        if (wide_i && hi_addr == AW'(BASE + j)) begin
          hi_b       = live_byte_i[j];
          latch_o[j] = 1'b1;
        end
      end
    end
  end

  assign data_o = wide_i ? {hi_b, lo_b} : {{BYTE_W{1'b0}}, lo_b};
  assign err_o  = en_i && wide_i && addr_i[0];
endmodule

// File: rtl/nbr_byte_rf.sv
module nbr_byte_rf #(
  parameter int unsigned NREG   = nbr_rf_pkg::RF_NREG,
  parameter int unsigned BYTE_W = nbr_rf_pkg::RF_BYTE_W,
  parameter int unsigned NMEMB  = nbr_rf_pkg::RF_NMEMB,
  localparam int unsigned AW    = $clog2(NREG),
  localparam int unsigned IDX_W = $clog2(NMEMB),
  localparam int unsigned NSLOT = 2 * (NMEMB - 1),
  localparam int unsigned BASE  = NREG - NSLOT
) (
  input  logic                               clk_i,
  input  logic                               rst_ni,
  input  logic [IDX_W-1:0]                   elem_idx_i,
  input  logic [NMEMB-1:0][2*BYTE_W-1:0]     bus_data_i,
  input  logic [NMEMB-1:0]                   bus_vld_i,
  input  logic                               rd_a_en_i,
  input  logic                               rd_a_wide_i,
  input  logic [AW-1:0]                      rd_a_addr_i,
  output logic [2*BYTE_W-1:0]                rd_a_data_o,
  output logic                               rd_a_err_o,
  input  logic                               rd_b_en_i,
  input  logic                               rd_b_wide_i,
  input  logic [AW-1:0]                      rd_b_addr_i,
  output logic [2*BYTE_W-1:0]                rd_b_data_o,
  output logic                               rd_b_err_o,
  input  logic                               wr_en_i,
  input  logic                               wr_wide_i,
  input  logic [AW-1:0]                      wr_addr_i,
  input  logic [2*BYTE_W-1:0]                wr_data_i
);
  logic [NREG-1:0][BYTE_W-1:0]  rf_q, rf_d;
  logic [NSLOT-1:0][BYTE_W-1:0] live_byte;
  logic [NSLOT-1:0]             live_vld, latch_a, latch_b;

  nbr_rf_map #(.NMEMB(NMEMB), .BYTE_W(BYTE_W)) i_map (
    .elem_idx_i (elem_idx_i),
    .bus_data_i (bus_data_i),
    .bus_vld_i  (bus_vld_i),
    .live_byte_o(live_byte),
    .live_vld_o (live_vld)
  );

  nbr_rf_rd_port #(.NREG(NREG), .BYTE_W(BYTE_W), .NSLOT(NSLOT)) i_rd_a (
    .en_i(rd_a_en_i), .wide_i(rd_a_wide_i), .addr_i(rd_a_addr_i),
    .regs_i(rf_q), .live_byte_i(live_byte), .live_vld_i(live_vld),
    .data_o(rd_a_data_o), .err_o(rd_a_err_o), .latch_o(latch_a)
  );

  nbr_rf_rd_port #(.NREG(NREG), .BYTE_W(BYTE_W), .NSLOT(NSLOT)) i_rd_b (
    .en_i(rd_b_en_i), .wide_i(rd_b_wide_i), .addr_i(rd_b_addr_i),
    .regs_i(rf_q), .live_byte_i(live_byte), .live_vld_i(live_vld),
    .data_o(rd_b_data_o), .err_o(rd_b_err_o), .latch_o(latch_b)
  );

  always_comb begin
    rf_d = rf_q;
    if (wr_en_i) begin
      if (wr_wide_i) begin
        rf_d[{wr_addr_i[AW-1:1], 1'b0}] = wr_data_i[BYTE_W-1:0];
        rf_d[{wr_addr_i[AW-1:1], 1'b1}] = wr_data_i[2*BYTE_W-1:BYTE_W];
      end else begin
        rf_d[wr_addr_i] = wr_data_i[BYTE_W-1:0];
      end
    end
    // bus latch overrides a same-cycle local write
    for (int j = 0; j < NSLOT; j++) begin
      if (latch_a[j] || latch_b[j]) rf_d[BASE+j] = live_byte[j];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rf_q <= '0;
    else         rf_q <= rf_d;
  end

  // R5
  plain_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !wr_wide_i && wr_addr_i < AW'(BASE))
    |=> rf_q[$past(wr_addr_i)] == $past(wr_data_i[BYTE_W-1:0]));

  for (genvar j = 0; j < NSLOT; j++) begin : g_chk
    // R7 R9
    bus_latch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (latch_a[j] || latch_b[j]) |=> rf_q[BASE+j] == $past(live_byte[j]));
    // R8
    bus_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!latch_a[j] && !latch_b[j] && !wr_en_i) |=> $stable(rf_q[BASE+j]));
    // R8
    no_latch_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !live_vld[j] |-> !(latch_a[j] || latch_b[j]));
  end
endmodule

// File: tb/test_nbr_byte_rf.sv
module test_nbr_byte_rf;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] idx = '0;
  logic [3:0][15:0] bus = '0;
  logic [3:0] vld = '0;
  logic a_en = 0, a_wide = 0, b_en = 0, b_wide = 0, w_en = 0, w_wide = 0;
  logic [4:0] a_addr = '0, b_addr = '0, w_addr = '0;
  logic [15:0] w_data = '0, a_data, b_data;
  logic a_err, b_err;
  logic [7:0] m [32];
  int total = 0, bad = 0;

  always #10 clk = ~clk;

  nbr_byte_rf i_nbr_byte_rf (
    .clk_i(clk), .rst_ni(rst_n), .elem_idx_i(idx), .bus_data_i(bus), .bus_vld_i(vld),
    .rd_a_en_i(a_en), .rd_a_wide_i(a_wide), .rd_a_addr_i(a_addr),
    .rd_a_data_o(a_data), .rd_a_err_o(a_err),
    .rd_b_en_i(b_en), .rd_b_wide_i(b_wide), .rd_b_addr_i(b_addr),
    .rd_b_data_o(b_data), .rd_b_err_o(b_err),
    .wr_en_i(w_en), .wr_wide_i(w_wide), .wr_addr_i(w_addr), .wr_data_i(w_data));

  function automatic int src_of(input int a);
    return (int'(idx) + (a - 26) / 2 + 1) % 4;
  endfunction

  function automatic logic [7:0] exp_byte(input logic en, input int a);
    if (en && a >= 26 && vld[src_of(a)])
      return (a % 2) ? bus[src_of(a)][15:8] : bus[src_of(a)][7:0];
    return m[a];
  endfunction

  function automatic logic [15:0] exp_rd(input logic en, input logic wide, input logic [4:0] a);
    int lo;
    lo = wide ? int'({a[4:1], 1'b0}) : int'(a);
    if (wide) return {exp_byte(en, lo + 1), exp_byte(en, lo)};
    return {8'h00, exp_byte(en, lo)};
  endfunction

  function automatic string tag_of(input logic en, input logic wide, input logic [4:0] a);
    if (wide && a[0]) return "R4";
    if (en && a >= 26) return "R7";
    if (wide) return "R3";
    return "R2";
  endfunction

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic latch_model(input logic en, input logic wide, input logic [4:0] a,
                             inout logic [7:0] nm [32]);
    int lo;
    lo = wide ? int'({a[4:1], 1'b0}) : int'(a);
    for (int r = lo; r <= (wide ? lo + 1 : lo); r++)
      if (en && r >= 26 && vld[src_of(r)])
        nm[r] = (r % 2) ? bus[src_of(r)][15:8] : bus[src_of(r)][7:0];
  endtask

  // inputs already set after a negedge; checks mid-phase, then commits the model at the edge
  task automatic run(input string tag);
    logic [7:0] nm [32];
    #5;
    chk(tag == "" ? tag_of(a_en, a_wide, a_addr) : tag, a_data, exp_rd(a_en, a_wide, a_addr));
    chk(tag == "" ? tag_of(b_en, b_wide, b_addr) : tag, b_data, exp_rd(b_en, b_wide, b_addr));
    chk("R4", {15'd0, a_err}, {15'd0, a_en && a_wide && a_addr[0]});
    chk("R4", {15'd0, b_err}, {15'd0, b_en && b_wide && b_addr[0]});
    nm = m;
    if (w_en) begin
      if (w_wide) begin
        nm[{w_addr[4:1], 1'b0}] = w_data[7:0];
        nm[{w_addr[4:1], 1'b1}] = w_data[15:8];
      end else nm[w_addr] = w_data[7:0];
    end
    latch_model(a_en, a_wide, a_addr, nm);
    latch_model(b_en, b_wide, b_addr, nm);
    @(posedge clk);
    m = nm;
    @(negedge clk);
  endtask

  task automatic idle();
    a_en = 0; b_en = 0; w_en = 0; a_wide = 0; b_wide = 0; w_wide = 0;
  endtask

  initial begin
    #(20 * 150000);
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 32; i++) m[i] = 8'h00;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: every register zero after reset, read on both ports
    for (int a = 0; a < 32; a += 2) begin
      a_addr = 5'(a); b_addr = 5'(a + 1);
      run("R1");
    end

    // R5: byte writes everywhere, then an odd-address wide write
    for (int a = 0; a < 32; a++) begin
      w_en = 1; w_wide = 0; w_addr = 5'(a); w_data = {8'hAA, 8'(a * 7 + 3)};
      a_addr = 5'(a); run("R5");
    end
    w_en = 1; w_wide = 1; w_addr = 5'd5; w_data = 16'hBEEF; run("R5");
    idle();
    a_wide = 1; a_addr = 5'd4; b_wide = 1; b_en = 1; b_addr = 5'd5;
    run("R5"); // R3 on port A, R4 on port B
    idle();

    // R6 R7: each element index, distinct buses, own member holds a decoy
    for (int k = 0; k < 4; k++) begin
      idx = 2'(k);
      for (int s = 0; s < 4; s++) bus[s] = (s == k) ? 16'hDEAD : {8'(8'h10 * s + 8'h2 + k), 8'(8'h10 * s + 8'h1 + k)};
      vld = 4'hF;
      a_en = 1; a_wide = 1; a_addr = 5'd26; b_en = 1; b_wide = 1; b_addr = 5'd28;
      run("R6");
      a_addr = 5'd30; b_en = 0; b_wide = 0; b_addr = 5'd27;
      run("R6");
      idle(); vld = 4'h0;
      for (int a = 26; a < 32; a++) begin a_addr = 5'(a); a_en = 1; run("R6"); end
      idle();
    end

    // R8: bus valid but port disabled must not latch; idle bus returns stored
    idx = 2'd1;
    for (int s = 0; s < 4; s++) bus[s] = 16'h5A00 + 16'(s);
    vld = 4'hF; a_en = 0; a_wide = 1; a_addr = 5'd28; b_en = 0; b_addr = 5'd31;
    run("R8");
    vld = 4'h0; a_en = 1; b_en = 1;
    run("R8");
    vld = 4'b0100; a_addr = 5'd26; // source of 26/27 for idx 1 is member 2; 28 source idle
    b_wide = 1; b_addr = 5'd28;
    run("R8");
    idle(); vld = 4'h0; a_wide = 1; a_addr = 5'd26; run("R8");

    // R9: write and latch on the same register
    idx = 2'd3; bus[0] = 16'h1234; vld = 4'b0001;
    w_en = 1; w_wide = 0; w_addr = 5'd27; w_data = 16'h00EE;
    a_en = 1; a_wide = 0; a_addr = 5'd27;
    run("R9");
    w_wide = 1; w_addr = 5'd26; w_data = 16'h7788; bus[0] = 16'hC3A5;
    a_wide = 1; a_addr = 5'd26;
    run("R9");
    idle(); vld = 4'h0; a_wide = 1; a_addr = 5'd26; run("R9");
    idle();

    // random mix
    for (int n = 0; n < 3000; n++) begin
      if (n % 500 == 0) idx = 2'($urandom_range(0, 3));
      for (int s = 0; s < 4; s++) bus[s] = 16'($urandom);
      vld = 4'($urandom);
      a_en = 1'($urandom); a_wide = 1'($urandom);
      a_addr = ($urandom_range(0, 9) < 4) ? 5'($urandom_range(26, 31)) : 5'($urandom);
      b_en = 1'($urandom); b_wide = 1'($urandom);
      b_addr = ($urandom_range(0, 9) < 4) ? 5'($urandom_range(26, 31)) : 5'($urandom);
      w_en = 1'($urandom); w_wide = 1'($urandom); w_addr = 5'($urandom); w_data = 16'($urandom);
      run("");
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule